// File: doc/BRIEF.md
# Mixed Page-Size Translation Cache

This block keeps recently completed address translations for a device-side I/O memory management unit. A small fully associative array holds entries of three page sizes (1 MB, 64 KB and 4 KB) side by side. Each entry compares only the virtual address bits that its page size leaves significant. The lookup port answers in the same cycle with hit, physical address and page size. The table walker writes results through the fill port. Two flush commands remove entries: one clears the whole array, the other clears only the entries that cover a given page.

Software can map overlapping regions by mistake. When more than one valid entry matches a lookup, the block does not pick a winner. It reports a multi-hit fault on the read or the write flag, according to the direction of the access. Replacement is least recently used. A fill goes to the lowest-numbered invalid entry first. Only when every entry is valid does it evict the least recently used one.

Top module: `mstlb_top`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses.
- R2: Page size codes are 0 = 4 KB (tag is virtual address bits [31:12]), 1 = 64 KB (bits [31:16]) and 2 = 1 MB (bits [31:20]). A hit reports the code of the matching entry on `lk_size`.
- R3: On a hit, `lk_pa` takes the entry's physical base above the page offset and the lookup address bits inside the page offset. For example, a 64 KB hit returns {base[31:16], va[15:0]}.
- R4: When a valid lookup matches two or more valid entries, `lk_hit` is low. `mh_rd` is high for a read (`lk_write` = 0) and `mh_wr` is high for a write (`lk_write` = 1).
- R5: An accepted fill is written into the lowest-numbered invalid entry. If all entries are valid, it replaces the least recently used entry.
- R6: An accepted fill and a single-entry lookup hit both mark their entry as most recently used at the next clock edge. When both occur in the same cycle, the fill wins.
- R7: `flush_all` invalidates every entry at the next clock edge.
- R8: `flush_one` invalidates, at the next clock edge, every entry whose page covers the 4 KB page `flush_vpn` (address bits [31:12]). Entries that do not cover that page stay valid.
- R9: A fill that arrives in the same cycle as either flush command is dropped.
- R10: A fill with size code 3 is dropped.
- R11: While `lk_valid` is low, `lk_hit`, `mh_rd` and `mh_wr` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| lk_write | input | 1 | Lookup direction, 1 = write |
| lk_hit | output | 1 | Exactly one entry matched |
| lk_pa | output | 32 | Translated physical address (0 when not hit) |
| lk_size | output | 2 | Page size code of the hit entry |
| mh_rd | output | 1 | Multi-hit fault on a read lookup |
| mh_wr | output | 1 | Multi-hit fault on a write lookup |
| fill_valid | input | 1 | Fill request from the walker |
| fill_vpn | input | 20 | Fill virtual page number, address bits [31:12] |
| fill_ppn | input | 20 | Fill physical page number, address bits [31:12] |
| fill_size | input | 2 | Fill page size code |
| flush_all | input | 1 | Invalidate every entry |
| flush_one | input | 1 | Invalidate entries covering `flush_vpn` |
| flush_vpn | input | 20 | Page to flush, address bits [31:12] |

## Verification
The bench deliberately fills a 1 MB page and a 4 KB page inside it. It then expects a read fault and a write fault with no hit. A design that resolved the overlap by priority would return a hit instead. Single-entry flushes are aimed at an interior page of a large entry: a design that compared the flush address with the full tag would leave the large page alive. The bench also runs long random sequences in which every entry is valid. These sequences check which entry the next fill evicts, and they catch any LRU update that misses a hit, or that lets a same-cycle hit override a fill. Fills that collide with flushes, and fills with the reserved size code, must not make any entry valid.

// File: rtl/tlb_pkg.sv
// Shared types and helpers for the mixed page-size translation cache.
// Assumes 32-bit virtual and physical addresses with a 4 KB minimum page.
package tlb_pkg;
    localparam int VA_W     = 32;
    localparam int PAGE_LSB = 12;
    localparam int VPN_W    = VA_W - PAGE_LSB;

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_64K = 2'd1,
        PG_1M  = 2'd2,
        PG_BAD = 2'd3
    } pg_size_e;

    // Page-number bits that take part in the tag compare for a given size
    function automatic logic [VPN_W-1:0] vpn_mask(pg_size_e sz);
        case (sz)
            PG_4K:   vpn_mask = {VPN_W{1'b1}};
            PG_64K:  vpn_mask = {{(VPN_W-4){1'b1}}, 4'h0};
            PG_1M:   vpn_mask = {{(VPN_W-8){1'b1}}, 8'h00};
            default: vpn_mask = '0;
        endcase
    endfunction
endpackage

// File: rtl/tlb_cam_slot.sv
// One entry of the translation cache: storage plus size-masked compare
// against the lookup page and the flush page.
// Assumes wr_en is only raised for a legal size code and never together with
// a flush (the top module guarantees both).
module tlb_cam_slot
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [VPN_W-1:0] wr_ppn,
    input  pg_size_e         wr_size,
    input  logic             flush_all,
    input  logic             flush_one,
    input  logic [VPN_W-1:0] flush_vpn,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             valid_o,
    output logic             lk_match_o,
    output pg_size_e         size_o,
    output logic [VPN_W-1:0] ppn_o
);
    logic             valid_q;
    logic [VPN_W-1:0] tag_q;
    logic [VPN_W-1:0] ppn_q;
    pg_size_e         size_q;
    logic [VPN_W-1:0] cmp_mask;
    logic             fl_cover;
    logic             kill;

    // Compare masks follow the stored page size
    always_comb begin
        cmp_mask   = vpn_mask(size_q);
        lk_match_o = valid_q && (((lk_vpn ^ tag_q) & cmp_mask) == '0);
        fl_cover   = valid_q && (((flush_vpn ^ tag_q) & cmp_mask) == '0);
        kill       = flush_all || (flush_one && fl_cover);
    end

    // Entry state: invalidate on flush, load on fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
            ppn_q   <= '0;
            size_q  <= PG_4K;
        end else if (kill) begin
            valid_q <= 1'b0;
        end else if (wr_en) begin
            valid_q <= 1'b1;
            tag_q   <= wr_vpn & vpn_mask(wr_size);
            ppn_q   <= wr_ppn & vpn_mask(wr_size);
            size_q  <= wr_size;
        end
    end

    assign valid_o = valid_q;
    assign size_o  = size_q;
    assign ppn_o   = ppn_q;

    // R7
    flush_all_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> !valid_q);
    // R8
    flush_one_covers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_one && fl_cover) |=> !valid_q);
endmodule

// File: rtl/tlb_lru_age.sv
// Least-recently-used tracker built from one age counter per entry.
// The ages always form a permutation of 0..N-1 and age N-1 is the oldest entry.
// Also picks the fill slot: lowest invalid entry, otherwise the oldest entry.
// Assumes N is a power of two, at least 2.
module tlb_lru_age #(
    parameter  int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch_en,
    input  logic [IW-1:0] touch_idx,
    input  logic [N-1:0]  valid_i,
    output logic [IW-1:0] fill_idx_o
);
    logic [IW-1:0] age_q [N];
    logic [N-1:0]  oldest_vec;
    logic [IW-1:0] victim;

    // Age update: the touched entry becomes youngest, younger ones age by one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
        end else if (touch_en) begin
            for (int i = 0; i < N; i++) begin
                if (IW'(i) == touch_idx)            age_q[i] <= '0;
                else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    // Victim search, then the invalid-first override
    always_comb begin
        victim = '0;
        for (int i = 0; i < N; i++) begin
            oldest_vec[i] = (age_q[i] == IW'(N - 1));
            if (oldest_vec[i]) victim = IW'(i);
        end
        fill_idx_o = victim;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_i[i]) fill_idx_o = IW'(i);
        end
    end

    // R6
    lru_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest_vec) == 1);
endmodule

// File: rtl/mstlb_top.sv
// Fully associative translation cache holding 1 MB, 64 KB and 4 KB pages.
// Lookups answer combinationally. Fills, flushes and LRU updates take effect
// at the next clock edge. Overlapping matches are reported as multi-hit
// faults, split by access direction.
// Assumes the walker presents page numbers, with address bits [31:12] only.
module mstlb_top
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_va,
    input  logic             lk_write,
    output logic             lk_hit,
    output logic [VA_W-1:0]  lk_pa,
    output logic [1:0]       lk_size,
    output logic             mh_rd,
    output logic             mh_wr,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [VPN_W-1:0] fill_ppn,
    input  logic [1:0]       fill_size,
    input  logic             flush_all,
    input  logic             flush_one,
    input  logic [VPN_W-1:0] flush_vpn
);
    localparam int IW  = $clog2(NUM_ENTRIES);
    localparam int CW  = $clog2(NUM_ENTRIES + 1);

    logic [NUM_ENTRIES-1:0] valid_vec;
    logic [NUM_ENTRIES-1:0] match_vec;
    pg_size_e               slot_size [NUM_ENTRIES];
    logic [VPN_W-1:0]       slot_ppn  [NUM_ENTRIES];
    logic [IW-1:0]          fill_idx;
    logic [IW-1:0]          hit_idx;
    logic [CW-1:0]          match_cnt;
    logic                   fill_go;
    logic                   touch_en;
    logic [IW-1:0]          touch_idx;
    logic [VPN_W-1:0]       hit_mask;
    logic [VPN_W-1:0]       lk_vpn;

    assign lk_vpn  = lk_va[VA_W-1:PAGE_LSB];
    // A fill is taken only without a flush and with a legal size
    assign fill_go = fill_valid && !flush_all && !flush_one && (fill_size != 2'd3);

    genvar g;
    generate
        for (g = 0; g < NUM_ENTRIES; g++) begin : g_slot
            tlb_cam_slot u_slot (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr_en      (fill_go && (fill_idx == IW'(g))),
                .wr_vpn     (fill_vpn),
                .wr_ppn     (fill_ppn),
                .wr_size    (pg_size_e'(fill_size)),
                .flush_all  (flush_all),
                .flush_one  (flush_one),
                .flush_vpn  (flush_vpn),
                .lk_vpn     (lk_vpn),
                .valid_o    (valid_vec[g]),
                .lk_match_o (match_vec[g]),
                .size_o     (slot_size[g]),
                .ppn_o      (slot_ppn[g])
            );
        end
    endgenerate

    // Count matches and find the matching index
    always_comb begin
        match_cnt = '0;
        hit_idx   = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (match_vec[i]) begin
                match_cnt = match_cnt + 1'b1;
                hit_idx   = IW'(i);
            end
        end
    end

    // Result formation: a hit needs exactly one match, otherwise fault or miss
    always_comb begin
        lk_hit   = lk_valid && (match_cnt == CW'(1));
        mh_rd    = lk_valid && (match_cnt > CW'(1)) && !lk_write;
        mh_wr    = lk_valid && (match_cnt > CW'(1)) && lk_write;
        hit_mask = vpn_mask(slot_size[hit_idx]);
        lk_pa    = '0;
        lk_size  = 2'd0;
        if (lk_hit) begin
            lk_pa   = {(slot_ppn[hit_idx] & hit_mask) | (lk_vpn & ~hit_mask),
                       lk_va[PAGE_LSB-1:0]};
            lk_size = slot_size[hit_idx];
        end
    end

    // Recency update: a fill outranks a lookup hit in the same cycle
    assign touch_en  = fill_go || lk_hit;
    assign touch_idx = fill_go ? fill_idx : hit_idx;

    tlb_lru_age #(.N(NUM_ENTRIES)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .valid_i    (valid_vec),
        .fill_idx_o (fill_idx)
    );

    // R4
    multihit_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mh_rd || mh_wr) |-> (!lk_hit && !(mh_rd && mh_wr)));
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !mh_rd && !mh_wr));
    // R5
    fill_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_go && !(&valid_vec)) |=> ($countones(valid_vec) == $past($countones(valid_vec)) + 1));
    // R9
    flush_beats_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && (flush_all || flush_one)) |=> ($countones(valid_vec) <= $past($countones(valid_vec))));
    // R10
    bad_size_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fill_size == 2'd3 && !flush_all && !flush_one) |=> (valid_vec == $past(valid_vec)));
endmodule

// File: tb/mstlb_top_bench.sv
module mstlb_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 0, lk_write = 0;
    logic [31:0] lk_va = '0;
    logic        lk_hit, mh_rd, mh_wr;
    logic [31:0] lk_pa;
    logic [1:0]  lk_size;
    logic        fill_valid = 0;
    logic [19:0] fill_vpn = '0, fill_ppn = '0;
    logic [1:0]  fill_size = '0;
    logic        flush_all = 0, flush_one = 0;
    logic [19:0] flush_vpn = '0;

    int tests = 0, fails = 0;
    bit done = 0;

    // Reference model state
    bit          m_v   [8];
    logic [19:0] m_tag [8];
    logic [19:0] m_ppn [8];
    logic [1:0]  m_sz  [8];
    int          m_st  [8];
    int          m_time = 0;

    always #5 clk = ~clk;

    mstlb_top u_mstlb_top (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va), .lk_write(lk_write),
        .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_size(lk_size), .mh_rd(mh_rd), .mh_wr(mh_wr),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_size(fill_size),
        .flush_all(flush_all), .flush_one(flush_one), .flush_vpn(flush_vpn)
    );

    function automatic logic [19:0] msk(input logic [1:0] s);
        case (s)
            2'd0:    return 20'hFFFFF;
            2'd1:    return 20'hFFFF0;
            default: return 20'hFFF00;
        endcase
    endfunction

    function automatic bit covers(input int i, input logic [19:0] vpn);
        return m_v[i] && (((vpn ^ m_tag[i]) & msk(m_sz[i])) == 20'h0);
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One cycle: check outputs mid-cycle against the model, then advance both
    task automatic step(input string tag);
        int cnt, idx, slot, oldest;
        bit exp_hit, go;
        logic [31:0] exp_pa;
        #4;
        cnt = 0; idx = 0;
        for (int i = 0; i < 8; i++) if (covers(i, lk_va[31:12])) begin cnt++; idx = i; end
        exp_hit = lk_valid && cnt == 1;
        chk(tag, "hit", {31'b0, lk_hit}, {31'b0, exp_hit});
        if (exp_hit) begin
            exp_pa = {(m_ppn[idx] & msk(m_sz[idx])) | (lk_va[31:12] & ~msk(m_sz[idx])), lk_va[11:0]};
            chk("R3", "pa", lk_pa, exp_pa);
            chk("R2", "size", {30'b0, lk_size}, {30'b0, m_sz[idx]});
        end
        chk("R4", "mh_rd", {31'b0, mh_rd}, {31'b0, (lk_valid && cnt > 1 && !lk_write)});
        chk("R4", "mh_wr", {31'b0, mh_wr}, {31'b0, (lk_valid && cnt > 1 && lk_write)});
        @(posedge clk);
        #1;
        go = fill_valid && !flush_all && !flush_one && fill_size != 2'd3;
        if (flush_all) for (int i = 0; i < 8; i++) m_v[i] = 0;
        else if (flush_one) for (int i = 0; i < 8; i++) if (covers(i, flush_vpn)) m_v[i] = 0;
        if (go) begin
            slot = -1; oldest = 0;
            for (int i = 7; i >= 0; i--) if (!m_v[i]) slot = i;
            if (slot < 0) begin
                for (int i = 1; i < 8; i++) if (m_st[i] < m_st[oldest]) oldest = i;
                slot = oldest;
            end
            m_v[slot] = 1; m_tag[slot] = fill_vpn & msk(fill_size);
            m_ppn[slot] = fill_ppn & msk(fill_size); m_sz[slot] = fill_size;
            m_time++; m_st[slot] = m_time;
        end else if (exp_hit) begin
            m_time++; m_st[idx] = m_time;
        end
        @(negedge clk);
    endtask

    task automatic idle_in();
        lk_valid = 0; lk_write = 0; fill_valid = 0; flush_all = 0; flush_one = 0;
    endtask

    task automatic do_fill(input logic [19:0] v, input logic [19:0] p, input logic [1:0] s, input string tag);
        idle_in(); fill_valid = 1; fill_vpn = v; fill_ppn = p; fill_size = s;
        step(tag);
        idle_in();
    endtask

    task automatic do_look(input logic [31:0] va, input bit wr, input string tag);
        idle_in(); lk_valid = 1; lk_va = va; lk_write = wr;
        step(tag);
        idle_in();
    endtask

    task automatic expect_hit(input logic [31:0] va, input bit h, input string tag);
        idle_in(); lk_valid = 1; lk_va = va;
        #4; chk(tag, "directed hit", {31'b0, lk_hit}, {31'b0, h});
        #1; step(tag);
        idle_in();
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin m_v[i] = 0; m_st[i] = 0; m_tag[i] = 0; m_ppn[i] = 0; m_sz[i] = 0; end
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: nothing valid after reset
        expect_hit(32'h0000_0000, 0, "R1");
        expect_hit(32'h1234_5678, 0, "R1");

        // R5: eight 4 KB fills land in invalid slots, all hit afterwards
        for (int i = 0; i < 8; i++) do_fill(20'h00100 + 20'(i), 20'h80000 + 20'(i), 2'd0, "R5");
        for (int i = 0; i < 8; i++) expect_hit({20'h00100 + 20'(i), 12'h00c}, 1, "R5");
        // R6: touch page 0x100 again, so the LRU entry is 0x101
        do_look({20'h00100, 12'h0}, 0, "R6");
        do_fill(20'h00200, 20'h90000, 2'd0, "R6");
        expect_hit({20'h00101, 12'h0}, 0, "R6");
        expect_hit({20'h00100, 12'h0}, 1, "R6");
        expect_hit({20'h00200, 12'h0}, 1, "R5");

        // R6: a fill and a hit in the same cycle; the fill gets the recency update
        idle_in(); lk_valid = 1; lk_va = {20'h00102, 12'h0};
        fill_valid = 1; fill_vpn = 20'h00300; fill_ppn = 20'h11111; fill_size = 2'd0;
        step("R6");
        do_fill(20'h00301, 20'h22222, 2'd0, "R6");
        expect_hit({20'h00300, 12'h0}, 1, "R6");

        // R7: flush everything
        idle_in(); flush_all = 1; step("R7"); idle_in();
        expect_hit({20'h00300, 12'h0}, 0, "R7");
        expect_hit({20'h00200, 12'h0}, 0, "R7");

        // R10: the reserved size code is dropped
        do_fill(20'h00400, 20'h33333, 2'd3, "R10");
        expect_hit({20'h00400, 12'h0}, 0, "R10");

        // R9: a fill together with a flush is dropped
        idle_in(); fill_valid = 1; fill_vpn = 20'h00500; fill_ppn = 20'h44444; fill_size = 2'd0;
        flush_one = 1; flush_vpn = 20'hFFFFF; step("R9"); idle_in();
        expect_hit({20'h00500, 12'h0}, 0, "R9");
        idle_in(); fill_valid = 1; fill_vpn = 20'h00501; fill_size = 2'd1; flush_all = 1; step("R9"); idle_in();
        expect_hit({20'h00501, 12'h0}, 0, "R9");

        // R8: a flush aimed at an interior page of a 1 MB entry; a 64 KB entry elsewhere survives
        do_fill(20'hABC00, 20'h12300, 2'd2, "R8");
        do_fill(20'h55550, 20'h66660, 2'd1, "R8");
        expect_hit(32'hABC4_5123, 1, "R8");
        idle_in(); flush_one = 1; flush_vpn = 20'hABC37; step("R8"); idle_in();
        expect_hit(32'hABC0_0000, 0, "R8");
        expect_hit(32'h5555_9abc, 1, "R8");

        // R4: overlapping 1 MB and 4 KB entries fault on both directions
        do_fill(20'h12300, 20'h70000, 2'd2, "R4");
        do_fill(20'h12345, 20'h00777, 2'd0, "R4");
        do_look(32'h1234_5678, 0, "R4");
        do_look(32'h1234_5678, 1, "R4");
        expect_hit(32'h1234_6abc, 1, "R3");

        // R11: no lookup request, no result
        idle_in(); lk_va = 32'h1234_5678; step("R11");

        // Random mix on a small address pool so overlaps and hits are frequent
        for (int n = 0; n < 4000; n++) begin
            int r;
            idle_in();
            lk_valid = ($urandom % 4) != 0;
            lk_write = $urandom % 2;
            lk_va = {8'h5A, 4'($urandom % 3), 4'($urandom % 3), 4'($urandom % 4), 12'($urandom)};
            if (($urandom % 3) == 0) begin
                fill_valid = 1;
                fill_vpn = {8'h5A, 4'($urandom % 3), 4'($urandom % 3), 4'($urandom % 4)};
                fill_ppn = 20'($urandom);
                r = $urandom % 16;
                fill_size = (r < 7) ? 2'd0 : (r < 12) ? 2'd1 : (r < 15) ? 2'd2 : 2'd3;
            end
            r = $urandom % 64;
            if (r == 0) flush_all = 1;
            else if (r < 5) begin
                flush_one = 1;
                flush_vpn = {8'h5A, 4'($urandom % 3), 4'($urandom % 3), 4'($urandom % 4)};
            end
            step("R2");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #(10 * 100000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule